// File: doc/BRIEF.md
# Accelerator command and status controller

This block is the host-facing control core of a small programmable accelerator. Software writes an 8-bit command word through a plain register port. The controller decides whether the command is accepted. It then launches the matching engine with a one-cycle start pulse and reports its phase through an 8-bit status code. Commands are accepted only while the controller is idle, and unknown codes have no effect. The execution engine and the memory-wipe engines are outside the block. They are seen only as start outputs, a shared completion input, and the error inputs.

Each completed operation raises a done interrupt. The interrupt has a state bit, an enable bit and a test bit. Recoverable errors reported at completion are accumulated in a sticky error register and cause a recoverable alert.

A fatal error has a different path. It captures an 8-bit cause vector that then stays frozen, fires a fatal alert and starts an internal-state wipe. When that wipe completes, the controller settles in a locked state that only reset leaves. A control bit can promote software (recoverable) errors to fatal ones. Coming out of reset, the block first runs an internal wipe before it reaches idle.

Top module: `accel_ctrl`

## Requirements
- R1: After reset the status reads 0x04 and every other register reads 0. `intWipeStart` pulses for exactly one cycle after the first clock edge that follows reset release.
- R2: While the status is 0x04 with no fatal error pending, an `engineDone` pulse moves the status to 0x00 without raising the done interrupt.
- R3: In idle, a write of 0xD8, 0xC3 or 0x1E to the command word moves the status on the next cycle to 0x01, 0x02 or 0x03 respectively. In the same cycle the matching one of `execStart`, `dmemWipeStart` or `imemWipeStart` pulses for one cycle.
- R4: A command write with any other value, or any command write while the status is not 0x00, changes neither the status nor any start output.
- R5: `engineDone` while the status is 0x01, 0x02 or 0x03 returns the status to 0x00 and sets interrupt-state bit 0. It also ORs `recovErr` into error-register bits 7:0 and, if `recovErr` is nonzero, pulses `alertRecov` for one cycle.
- R6: Writing 1 to interrupt-state bit 0 clears it; writing 0 leaves it unchanged. Writing 1 to interrupt-test bit 0 sets it, and a set wins over a clear in the same cycle. `intrDone` is interrupt-state bit 0 AND interrupt-enable bit 0.
- R7: Control bit 0 (software errors fatal) resets to 0 and can be written only while the status is 0x00.
- R8: A nonzero `fatalErr` has the following effects. It pulses `alertFatal`, stores the vector in the fatal-cause register bits 7:0 and ORs it into error-register bits 23:16. It sets the status to 0x04 and pulses `intWipeStart`. The next `engineDone` then sets the status to 0xFF and raises interrupt-state bit 0 once. A fatal error takes priority over a command or completion in the same cycle.
- R9: With control bit 0 set, an operation that completes with a nonzero `recovErr` is handled as a fatal error with cause bit 7. It still records its recoverable bits, but it neither pulses `alertRecov` nor raises the done interrupt until the lock wipe completes.
- R10: Once a fatal cause is captured it stays frozen, and later fatal inputs are ignored. In status 0xFF, commands and `engineDone` have no effect.
- R11: Any write to the error register clears it while the status is 0x00 or 0xFF. Such a write is ignored while the status is 0x01 to 0x04. The fatal-cause register is not cleared.
- R12: Writing the alert-test word produces one-cycle pulses: bit 0 pulses `alertFatal` and bit 1 pulses `alertRecov`.
- R13: The word addresses are 0 status, 1 command, 2 control, 3 interrupt state, 4 interrupt enable, 5 interrupt test, 6 alert test, 7 error, and 8 fatal cause. The command, test and unmapped words read 0, and reserved bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register word address for read and write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for `regAddr` |
| engineDone | input | 1 | Completion pulse of the running operation or wipe |
| recovErr | input | 8 | Recoverable error bits, valid with `engineDone` |
| fatalErr | input | 8 | Fatal error cause bits, any cycle |
| execStart | output | 1 | Start pulse for program execution from address zero |
| dmemWipeStart | output | 1 | Start pulse for the data-memory wipe |
| imemWipeStart | output | 1 | Start pulse for the instruction-memory wipe |
| intWipeStart | output | 1 | Start pulse for the internal-state wipe |
| intrDone | output | 1 | Done interrupt |
| alertFatal | output | 1 | Fatal alert pulse |
| alertRecov | output | 1 | Recoverable alert pulse |

## Verification
The bench builds the block with the default ADDR_W of 4 and DATA_W of 32. With these values every mapped word is reachable, and so are the seven unmapped addresses 9 to 15, whose reads must return zero. The full 32-bit width exposes the reserved gaps in the error word between the recoverable and fatal halves. Running twice through reset brings both lock paths within reach: one from a raw fatal input during execution, and one from a promoted software error.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;

  localparam int CODE_W = 8;
  localparam int ERR_W  = 8;
  localparam int FATAL_LSB = 16;
  localparam int SW_FATAL_BIT = 7;

  localparam int A_STATUS  = 0;
  localparam int A_CMD     = 1;
  localparam int A_CTRL    = 2;
  localparam int A_INTR_ST = 3;
  localparam int A_INTR_EN = 4;
  localparam int A_INTR_TS = 5;
  localparam int A_ALERT_T = 6;
  localparam int A_ERR     = 7;
  localparam int A_CAUSE   = 8;

  localparam logic [CODE_W-1:0] CMD_RUN    = 8'hD8;
  localparam logic [CODE_W-1:0] CMD_CLR_D  = 8'hC3;
  localparam logic [CODE_W-1:0] CMD_CLR_I  = 8'h1E;

  typedef enum logic [CODE_W-1:0] {
    ST_IDLE     = 8'h00,
    ST_EXEC     = 8'h01,
    ST_WIPE_D   = 8'h02,
    ST_WIPE_I   = 8'h03,
    ST_WIPE_INT = 8'h04,
    ST_LOCKED   = 8'hFF
  } ctrl_state_e;

  typedef struct packed {
    logic             setDone;
    logic             recovCapture;
    logic             recovAlert;
    logic             fatalCapture;
    logic [ERR_W-1:0] fatalCause;
    logic             errWrOk;
    logic             ctrlWrOk;
  } strobe_t;

endpackage

// File: rtl/accel_ctrl_fsm.sv
module accel_ctrl_fsm
  import accel_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CODE_W-1:0] wrByte,
  input  logic              engineDone,
  input  logic [ERR_W-1:0]  recovErr,
  input  logic [ERR_W-1:0]  fatalErr,
  input  logic              swErrsFatal,
  output logic [CODE_W-1:0] stateCode,
  output strobe_t           strb,
  output logic              execStart,
  output logic              dmemWipeStart,
  output logic              imemWipeStart,
  output logic              intWipeStart
);

  ctrl_state_e stateQ, stateD;
  logic lockPendQ, lockPendD;
  logic armQ;
  logic execQ, dmemQ, imemQ, intQ;
  logic execD, dmemD, imemD, intD;
  logic setDone;

  logic cmdWr, busyOp, promote, fatalEvent;

  assign cmdWr   = regWrEn && (regAddr == ADDR_W'(A_CMD));
  assign busyOp  = (stateQ == ST_EXEC) || (stateQ == ST_WIPE_D) || (stateQ == ST_WIPE_I);
  assign promote = busyOp && engineDone && swErrsFatal && (|recovErr);
  assign fatalEvent = ((|fatalErr) || promote) && (stateQ != ST_LOCKED) && !lockPendQ;

  always_comb begin
    stateD    = stateQ;
    lockPendD = lockPendQ;
    execD     = 1'b0;
    dmemD     = 1'b0;
    imemD     = 1'b0;
    intD      = armQ;
    setDone   = 1'b0;
    if (fatalEvent) begin
      stateD    = ST_WIPE_INT;
      lockPendD = 1'b1;
      intD      = 1'b1;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (cmdWr) begin
            case (wrByte)
              CMD_RUN:   begin stateD = ST_EXEC;   execD = 1'b1; end
              CMD_CLR_D: begin stateD = ST_WIPE_D; dmemD = 1'b1; end
              CMD_CLR_I: begin stateD = ST_WIPE_I; imemD = 1'b1; end
              default: ;
            endcase
          end
        end
        ST_EXEC, ST_WIPE_D, ST_WIPE_I: begin
          if (engineDone) begin
            stateD  = ST_IDLE;
            setDone = 1'b1;
          end
        end
        ST_WIPE_INT: begin
          if (engineDone) begin
            if (lockPendQ) begin
              stateD  = ST_LOCKED;
              setDone = 1'b1;
            end else begin
              stateD = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_WIPE_INT;
      lockPendQ <= 1'b0;
      armQ      <= 1'b1;
      execQ     <= 1'b0;
      dmemQ     <= 1'b0;
      imemQ     <= 1'b0;
      intQ      <= 1'b0;
    end else begin
      stateQ    <= stateD;
      lockPendQ <= lockPendD;
      armQ      <= 1'b0;
      execQ     <= execD;
      dmemQ     <= dmemD;
      imemQ     <= imemD;
      intQ      <= intD;
    end
  end

  always_comb begin
    strb              = '0;
    strb.setDone      = setDone;
    strb.recovCapture = busyOp && engineDone;
    strb.recovAlert   = busyOp && engineDone && !fatalEvent && (|recovErr);
    strb.fatalCapture = fatalEvent;
    strb.fatalCause   = fatalErr | (promote ? ERR_W'(1 << SW_FATAL_BIT) : '0);
    strb.errWrOk      = (stateQ == ST_IDLE) || (stateQ == ST_LOCKED);
    strb.ctrlWrOk     = (stateQ == ST_IDLE);
  end

  assign stateCode     = stateQ;
  assign execStart     = execQ;
  assign dmemWipeStart = dmemQ;
  assign imemWipeStart = imemQ;
  assign intWipeStart  = intQ;

  // R3: at most one operation start at a time
  p_one_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({execQ, dmemQ, imemQ}));

  // R3: entering execution is accompanied by the execute start pulse
  p_exec_launch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_EXEC && $past(stateQ) != ST_EXEC) |-> execQ);

  // R4: no command start is issued from a non-idle state
  p_no_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |=> !(execQ || dmemQ || imemQ));

  // R10: the locked state is terminal until reset
  p_lock_terminal_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_LOCKED) |-> (stateQ == ST_LOCKED));

endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [1:0]        wrBits,
  input  logic [ERR_W-1:0]  recovErr,
  input  strobe_t           strb,
  input  logic [CODE_W-1:0] stateCode,
  output logic [DATA_W-1:0] regRdData,
  output logic              swErrsFatal,
  output logic              intrDone,
  output logic              alertFatal,
  output logic              alertRecov
);

  logic intrStQ, intrEnQ, ctrlQ, alertFQ, alertRQ;
  logic [ERR_W-1:0] recovQ, fatMirQ, causeQ;

  logic wrSt, wrEn, wrTs, wrAl, wrCtl, wrErr;

  assign wrSt  = regWrEn && (regAddr == ADDR_W'(A_INTR_ST));
  assign wrEn  = regWrEn && (regAddr == ADDR_W'(A_INTR_EN));
  assign wrTs  = regWrEn && (regAddr == ADDR_W'(A_INTR_TS));
  assign wrAl  = regWrEn && (regAddr == ADDR_W'(A_ALERT_T));
  assign wrCtl = regWrEn && (regAddr == ADDR_W'(A_CTRL));
  assign wrErr = regWrEn && (regAddr == ADDR_W'(A_ERR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intrStQ <= 1'b0;
      intrEnQ <= 1'b0;
      ctrlQ   <= 1'b0;
      alertFQ <= 1'b0;
      alertRQ <= 1'b0;
      recovQ  <= '0;
      fatMirQ <= '0;
      causeQ  <= '0;
    end else begin
      if (strb.setDone || (wrTs && wrBits[0])) begin
        intrStQ <= 1'b1;
      end else if (wrSt && wrBits[0]) begin
        intrStQ <= 1'b0;
      end
      if (wrEn) begin
        intrEnQ <= wrBits[0];
      end
      if (wrCtl && strb.ctrlWrOk) begin
        ctrlQ <= wrBits[0];
      end
      alertFQ <= strb.fatalCapture | (wrAl & wrBits[0]);
      alertRQ <= strb.recovAlert | (wrAl & wrBits[1]);
      if (wrErr && strb.errWrOk && !strb.fatalCapture && !strb.recovCapture) begin
        recovQ  <= '0;
        fatMirQ <= '0;
      end else begin
        if (strb.recovCapture) recovQ <= recovQ | recovErr;
        if (strb.fatalCapture) fatMirQ <= fatMirQ | strb.fatalCause;
      end
      if (strb.fatalCapture) begin
        causeQ <= strb.fatalCause;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(A_STATUS):  regRdData[CODE_W-1:0] = stateCode;
      ADDR_W'(A_CTRL):    regRdData[0] = ctrlQ;
      ADDR_W'(A_INTR_ST): regRdData[0] = intrStQ;
      ADDR_W'(A_INTR_EN): regRdData[0] = intrEnQ;
      ADDR_W'(A_ERR): begin
        regRdData[ERR_W-1:0] = recovQ;
        regRdData[FATAL_LSB +: ERR_W] = fatMirQ;
      end
      ADDR_W'(A_CAUSE):   regRdData[ERR_W-1:0] = causeQ;
      default: ;
    endcase
  end

  assign swErrsFatal = ctrlQ;
  assign intrDone    = intrStQ & intrEnQ;
  assign alertFatal  = alertFQ;
  assign alertRecov  = alertRQ;

  // R5: completion of an operation raises the done state bit
  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> intrStQ);

  // R10: a captured fatal cause never changes until reset
  p_cause_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|causeQ) |=> $stable(causeQ));

  // R11: the error register holds while an operation runs
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.errWrOk && !strb.recovCapture && !strb.fatalCapture) |=> $stable({recovQ, fatMirQ}));

  // R7: the control bit cannot change outside idle
  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlWrOk |=> $stable(ctrlQ));

endmodule

// File: rtl/accel_ctrl.sv
module accel_ctrl
  import accel_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              engineDone,
  input  logic [ERR_W-1:0]  recovErr,
  input  logic [ERR_W-1:0]  fatalErr,
  output logic              execStart,
  output logic              dmemWipeStart,
  output logic              imemWipeStart,
  output logic              intWipeStart,
  output logic              intrDone,
  output logic              alertFatal,
  output logic              alertRecov
);

  strobe_t strb;
  logic [CODE_W-1:0] stateCode;
  logic swErrsFatal;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:CODE_W];

  accel_ctrl_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .regAddr      (regAddr),
    .regWrEn      (regWrEn),
    .wrByte       (regWrData[CODE_W-1:0]),
    .engineDone   (engineDone),
    .recovErr     (recovErr),
    .fatalErr     (fatalErr),
    .swErrsFatal  (swErrsFatal),
    .stateCode    (stateCode),
    .strb         (strb),
    .execStart    (execStart),
    .dmemWipeStart(dmemWipeStart),
    .imemWipeStart(imemWipeStart),
    .intWipeStart (intWipeStart)
  );

  accel_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .wrBits     (regWrData[1:0]),
    .recovErr   (recovErr),
    .strb       (strb),
    .stateCode  (stateCode),
    .regRdData  (regRdData),
    .swErrsFatal(swErrsFatal),
    .intrDone   (intrDone),
    .alertFatal (alertFatal),
    .alertRecov (alertRecov)
  );

endmodule

// File: tb/test_accel_ctrl.sv
module test_accel_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engineDone = 1'b0;
  logic [7:0]  recovErr = '0;
  logic [7:0]  fatalErr = '0;
  logic execStart, dmemWipeStart, imemWipeStart, intWipeStart;
  logic intrDone, alertFatal, alertRecov;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;
  string curReq = "R1";

  accel_ctrl i_accel_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .engineDone(engineDone),
    .recovErr(recovErr), .fatalErr(fatalErr), .execStart(execStart),
    .dmemWipeStart(dmemWipeStart), .imemWipeStart(imemWipeStart),
    .intWipeStart(intWipeStart), .intrDone(intrDone),
    .alertFatal(alertFatal), .alertRecov(alertRecov)
  );

  always #4 clk = ~clk;

  // behavioural reference model, advanced on every rising edge
  int mS;
  bit mLp, mArm, mIntr, mEn, mCtrl;
  bit [7:0] mRec, mFm, mCa;
  bit [5:0] mPul;

  task automatic modelStep();
    bit busy, prom, fev, cmdW, setD, capR;
    int nS;
    bit [7:0] cause;
    bit [5:0] p;
    busy  = (mS == 1) || (mS == 2) || (mS == 3);
    prom  = busy && engineDone && mCtrl && (recovErr != 0);
    fev   = ((fatalErr != 0) || prom) && (mS != 255) && !mLp;
    cmdW  = regWrEn && (regAddr == 1);
    cause = fatalErr | (prom ? 8'h80 : 8'h00);
    capR  = busy && engineDone;
    setD  = 1'b0;
    nS    = mS;
    p     = '0;
    p[2]  = mArm;
    if (fev) begin
      nS = 4; mLp = 1'b1; p[2] = 1'b1;
    end else if (mS == 0 && cmdW) begin
      if (regWrData[7:0] == 8'hD8) begin nS = 1; p[5] = 1'b1; end
      else if (regWrData[7:0] == 8'hC3) begin nS = 2; p[4] = 1'b1; end
      else if (regWrData[7:0] == 8'h1E) begin nS = 3; p[3] = 1'b1; end
    end else if (busy && engineDone) begin
      nS = 0; setD = 1'b1;
    end else if (mS == 4 && engineDone) begin
      if (mLp) begin nS = 255; setD = 1'b1; end
      else nS = 0;
    end
    p[1] = fev || (regWrEn && regAddr == 6 && regWrData[0]);
    p[0] = (capR && !fev && recovErr != 0) || (regWrEn && regAddr == 6 && regWrData[1]);
    if (setD || (regWrEn && regAddr == 5 && regWrData[0])) mIntr = 1'b1;
    else if (regWrEn && regAddr == 3 && regWrData[0]) mIntr = 1'b0;
    if (regWrEn && regAddr == 4) mEn = regWrData[0];
    if (regWrEn && regAddr == 2 && mS == 0) mCtrl = regWrData[0];
    if (regWrEn && regAddr == 7 && (mS == 0 || mS == 255) && !fev && !capR) begin
      mRec = '0; mFm = '0;
    end else begin
      if (capR) mRec = mRec | recovErr;
      if (fev) mFm = mFm | cause;
    end
    if (fev) mCa = cause;
    mArm = 1'b0;
    mS = nS;
    mPul = p;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mS = 4; mLp = 0; mArm = 1; mIntr = 0; mEn = 0; mCtrl = 0;
      mRec = '0; mFm = '0; mCa = '0; mPul = '0;
    end else begin
      modelStep();
    end
  end

  function automatic logic [31:0] expRd(input logic [3:0] a);
    logic [31:0] r = '0;
    case (a)
      4'd0: r[7:0] = 8'(mS);
      4'd2: r[0] = mCtrl;
      4'd3: r[0] = mIntr;
      4'd4: r[0] = mEn;
      4'd7: begin r[7:0] = mRec; r[23:16] = mFm; end
      4'd8: r[7:0] = mCa;
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic cmpAll();
    chk("read", regRdData, expRd(regAddr));
    chk("pulses", 32'({execStart, dmemWipeStart, imemWipeStart, intWipeStart, alertFatal, alertRecov}),
        32'(mPul));
    chk("irq", 32'(intrDone), 32'(mIntr & mEn));
  endtask

  task automatic step();
    @(negedge clk);
    if (cmpOn) cmpAll();
    regWrEn = 1'b0; engineDone = 1'b0; recovErr = '0; fatalErr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(); regAddr = a; regWrEn = 1'b1; regWrData = d;
  endtask

  task automatic rd(input logic [3:0] a);
    step(); regAddr = a;
  endtask

  task automatic finish(input logic [7:0] r);
    step(); engineDone = 1'b1; recovErr = r;
  endtask

  task automatic doReset();
    cmpOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0; engineDone = 1'b0; recovErr = '0; fatalErr = '0; regAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1'b1;
  endtask

  initial begin
    // R1: reset values and the boot wipe launch
    curReq = "R1";
    doReset();
    step();
    chk("boot wipe pulse", 32'(intWipeStart), 32'd1);
    chk("status after reset", regRdData, 32'h4);
    for (int a = 1; a < 9; a++) rd(4'(a));
    idle(2);
    // R2: boot wipe completes quietly
    curReq = "R2";
    rd(0);
    finish(8'h00);
    step();
    chk("status idle", regRdData, 32'h0);
    chk("no done irq", 32'(intrDone), 32'd0);
    // R13: map, reserved bits, unmapped words
    curReq = "R13";
    wr(4, 32'hFFFF_FFFF);
    wr(1, 32'h0000_00FF);
    rd(1); rd(5); rd(6);
    for (int a = 9; a < 16; a++) rd(4'(a));
    step();
    chk("enable reserved bits", regRdData, 32'h0);
    rd(4);
    step();
    chk("enable reads one bit", regRdData, 32'h1);
    // R3: execute command and R5: completion
    curReq = "R3";
    wr(1, 32'hD8);
    rd(0);
    step();
    chk("status exec", regRdData, 32'h1);
    idle(3);
    curReq = "R5";
    finish(8'h00);
    idle(2);
    chk("irq raised", 32'(intrDone), 32'd1);
    // R6: interrupt state/test/enable
    curReq = "R6";
    wr(3, 32'h0);
    wr(3, 32'h1);
    rd(3);
    step();
    chk("cleared", regRdData, 32'h0);
    wr(5, 32'h1);
    rd(3);
    wr(4, 32'h0);
    idle(2);
    wr(4, 32'h1);
    wr(3, 32'h1);
    // R3: both wipes
    curReq = "R3";
    wr(1, 32'hC3);
    rd(0);
    idle(2);
    finish(8'h00);
    wr(1, 32'h1E);
    rd(0);
    idle(2);
    finish(8'h00);
    wr(3, 32'h1);
    // R4: illegal code, and commands while busy
    curReq = "R4";
    wr(1, 32'h55);
    wr(1, 32'hD9);
    rd(0);
    step();
    chk("still idle", regRdData, 32'h0);
    wr(1, 32'hD8);
    wr(1, 32'hC3);
    wr(1, 32'h1E);
    rd(0);
    step();
    chk("still exec", regRdData, 32'h1);
    // R11: error write ignored while busy
    curReq = "R11";
    wr(7, 32'hFFFF_FFFF);
    // R5: completion with recoverable errors
    curReq = "R5";
    finish(8'h05);
    rd(7);
    step();
    chk("recov bits", regRdData, 32'h5);
    idle(2);
    curReq = "R11";
    wr(1, 32'hC3);
    wr(7, 32'h0);
    rd(7);
    idle(1);
    finish(8'h00);
    wr(7, 32'h0);
    rd(7);
    step();
    chk("error cleared", regRdData, 32'h0);
    // R7: control bit
    curReq = "R7";
    wr(1, 32'h1E);
    wr(2, 32'h1);
    rd(2);
    step();
    chk("ctrl held busy", regRdData, 32'h0);
    finish(8'h00);
    wr(2, 32'h1);
    wr(2, 32'h0);
    rd(2);
    // R12: alert test
    curReq = "R12";
    wr(6, 32'h1);
    wr(6, 32'h2);
    wr(6, 32'h3);
    idle(2);
    // R8: fatal during execution, then lock
    curReq = "R8";
    wr(3, 32'h1);
    wr(1, 32'hD8);
    idle(2);
    step(); fatalErr = 8'h21; engineDone = 1'b1; recovErr = 8'h01;
    rd(0);
    step();
    chk("wipe after fatal", regRdData, 32'h4);
    // R10: later fatal inputs ignored
    curReq = "R10";
    step(); fatalErr = 8'h04;
    wr(7, 32'h0);
    rd(8);
    curReq = "R8";
    idle(2);
    finish(8'h00);
    rd(0);
    step();
    chk("locked", regRdData, 32'hFF);
    rd(7);
    step();
    chk("error mirror", regRdData, 32'h0021_0001);
    curReq = "R10";
    wr(1, 32'hD8);
    finish(8'h00);
    step(); fatalErr = 8'hFF;
    rd(8);
    step();
    chk("cause frozen", regRdData, 32'h21);
    curReq = "R11";
    wr(7, 32'h0);
    rd(7);
    step();
    chk("cleared while locked", regRdData, 32'h0);
    rd(8);
    // R9: promoted software error after a fresh reset
    curReq = "R1";
    doReset();
    idle(3);
    finish(8'h00);
    curReq = "R9";
    wr(2, 32'h1);
    wr(4, 32'h1);
    wr(1, 32'hD8);
    idle(2);
    finish(8'h02);
    rd(8);
    step();
    chk("promoted cause", regRdData, 32'h80);
    chk("no irq yet", 32'(intrDone), 32'd0);
    rd(7);
    idle(2);
    finish(8'h00);
    rd(0);
    idle(2);
    chk("irq at lock", 32'(intrDone), 32'd1);
    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule